// File: doc/BRIEF.md
# Attribute Table Stream Validator

This block checks, byte by byte, a stream that carries a table of device attribute substructures. The bytes arrive on a valid/data interface. The first byte of a table is flagged with a start marker and the last byte with an end marker. A fixed preamble of configurable length comes first. The validator skips the preamble for parsing but includes it in the running byte sum.

After the preamble, the stream is a sequence of substructures. Each one opens with a four-byte header: a type byte, a byte that must be zero, and a 16-bit length in little-endian order. The validator checks each length against the rule for its type. It also checks that each structure starts exactly where the previous one ended, and that the last structure ends exactly on the end marker. For every accepted structure, it stores the structure's offset and length in an entry table. A lookup port reads that table back by entry index.

Every error flag stays set until the next start marker. After the first framing error, parsing stops for the rest of the table. The block also keeps the 8-bit sum of all accepted bytes and provides the matching two's-complement checksum byte.

Top module: `attr_table_validator`

## Requirements
- R1: Header byte 0 is the type, byte 1 must be zero, and bytes 2 (low) and 3 (high) give the structure length in bytes. A nonzero byte 1 sets `err_bad_reserved`. A length of zero sets `err_bad_length`.
- R2: Types 0, 1 and 4 must have a length of exactly 24. Type 2 must have exactly 20. Type 3 must have exactly 8. Any other length for these types sets `err_bad_length`.
- R3: Type 5 is accepted only if its length is at least 16 and the length minus 16 is a multiple of 8. Otherwise `err_bad_length` is set.
- R4: A type value of 6 or more sets `err_reserved_type` and does not set `err_bad_length`.
- R5: Each structure starts at the previous structure's offset plus its length. If the end marker arrives on any byte other than the last byte of a structure, and that byte raised no other error, `err_truncated` is set.
- R6: When a structure's header is accepted, its start offset and its length are stored at the next free slot, and `entry_count` increments. `lk_offset`/`lk_length` return the slot selected by `lk_idx`, or zero for a slot that has not been filled.
- R7: The table holds `MAX_ENTRIES` entries. An accepted structure that finds the table full sets `err_overflow` and is not stored, and `entry_count` stays at `MAX_ENTRIES`. Parsing continues after an overflow.
- R8: A start marker clears every error flag, the entry count and the sum. Error flags never clear otherwise. After a length, reserved-byte or type error, no further structure is parsed or stored until the next start marker.
- R9: `byte_sum` is the 8-bit sum of every byte from the start marker through the current byte, preamble included. `checksum` equals 256 minus `byte_sum`, modulo 256.
- R10: The first `PRE_LEN` bytes are not parsed. Offsets count from the first byte after them, which is offset 0. An end marker inside the preamble sets `err_truncated`.
- R11: After reset, all outputs are zero. `finished` rises after the byte that carries the end marker and clears on the next start marker. Bytes that arrive after the end marker and before the next start marker are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_data | input | 8 | Stream byte |
| in_start | input | 1 | Marks the first byte of a table |
| in_end | input | 1 | Marks the last byte of a table |
| lk_idx | input | $clog2(MAX_ENTRIES) | Entry table read index |
| lk_offset | output | OFFW | Stored start offset of the selected entry |
| lk_length | output | 16 | Stored length of the selected entry |
| entry_count | output | $clog2(MAX_ENTRIES+1) | Number of stored entries |
| err_bad_length | output | 1 | Length does not fit its type (sticky) |
| err_bad_reserved | output | 1 | Nonzero reserved header byte (sticky) |
| err_reserved_type | output | 1 | Type value 6 or above (sticky) |
| err_truncated | output | 1 | End marker arrived mid-structure or mid-preamble (sticky) |
| err_overflow | output | 1 | Accepted structure found the table full (sticky) |
| byte_sum | output | 8 | Running 8-bit sum of accepted bytes |
| checksum | output | 8 | Two's complement of `byte_sum` |
| busy | output | 1 | A table is in progress |
| finished | output | 1 | End marker seen since the last start |

## Verification
The bench instantiates the block with a 4-byte preamble and an 8-entry table. The short preamble makes it cheap to test streams that end inside or exactly at the preamble boundary. The small table means random streams of up to ten structures regularly overflow it, which exercises the saturated count and the no-store rule. Every header length rule is met on both sides of its boundary. Random streams mix legal structures with one injected fault at a random position, so the bench also checks that parsing halts after an error and that error flags clear on a fresh start.

// File: rtl/atv_pkg.sv
package atv_pkg;

  typedef struct packed {
    logic bad_len;
    logic bad_rsv;
    logic rsv_type;
    logic trunc;
    logic ovf;
  } err_t;

  localparam logic [7:0] FIRST_RSVD_TYPE = 8'd6;
  localparam int         HDR_BYTES       = 4;

  // Length rule per type: fixed sizes, or a 16-byte head plus 8-byte records.
  function automatic logic len_rule_ok(input logic [7:0] typ, input logic [15:0] len);
    logic ok;
    unique case (typ)
      8'd0, 8'd1, 8'd4: ok = (len == 16'd24);
      8'd2:             ok = (len == 16'd20);
      8'd3:             ok = (len == 16'd8);
      8'd5:             ok = (len >= 16'd16) && (len[2:0] == 3'd0);
      default:          ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic type_is_reserved(input logic [7:0] typ);
    return typ >= FIRST_RSVD_TYPE;
  endfunction

  function automatic logic [7:0] to_checksum(input logic [7:0] s);
    return 8'(~s + 8'd1);
  endfunction

endpackage

// File: rtl/atv_hdr_rule.sv
module atv_hdr_rule
  import atv_pkg::*;
(
  input  logic [7:0]  typ,
  input  logic [15:0] len,
  output logic        len_ok,
  output logic        type_rsvd
);

  assign type_rsvd = type_is_reserved(typ);
  assign len_ok    = len_rule_ok(typ, len);

endmodule

// File: rtl/atv_byte_sum.sv
module atv_byte_sum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic [7:0] data,
  output logic [7:0] sum
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum <= '0;
    else if (en)   sum <= (clr ? 8'd0 : sum) + data;
  end

  assert_sum_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> sum == 8'($past(sum) + $past(data)));

  assert_sum_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr) |=> sum == $past(data));

endmodule

// File: rtl/atv_entry_table.sv
module atv_entry_table #(
  parameter int DEPTH = 64,
  parameter int OFFW  = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr,
  input  logic [OFFW-1:0] wr_off,
  input  logic [15:0]     wr_len,
  input  logic [IDXW-1:0] rd_idx,
  output logic [OFFW-1:0] rd_off,
  output logic [15:0]     rd_len,
  output logic [CNTW-1:0] count,
  output logic            full
);

  logic [OFFW-1:0] off_mem [DEPTH];
  logic [15:0]     len_mem [DEPTH];

  assign full = (count == CNTW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (clr)              count <= '0;
    else if (wr && !full)      count <= count + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_mem[g] <= '0;
        len_mem[g] <= '0;
      end else if (clr) begin
        off_mem[g] <= '0;
        len_mem[g] <= '0;
      end else if (wr && !full && count == CNTW'(g)) begin
        off_mem[g] <= wr_off;
        len_mem[g] <= wr_len;
      end
    end
  end

  always_comb begin
    rd_off = '0;
    rd_len = '0;
    if (CNTW'(rd_idx) < count) begin
      rd_off = off_mem[rd_idx];
      rd_len = len_mem[rd_idx];
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !full && !clr) |=> count == $past(count) + 1'b1);

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full);

endmodule

// File: rtl/attr_table_validator.sv
module attr_table_validator
  import atv_pkg::*;
#(
  parameter int PRE_LEN     = 36,
  parameter int MAX_ENTRIES = 64,
  parameter int OFFW        = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [7:0]                       in_data,
  input  logic                             in_start,
  input  logic                             in_end,
  input  logic [$clog2(MAX_ENTRIES)-1:0]   lk_idx,
  output logic [OFFW-1:0]                  lk_offset,
  output logic [15:0]                      lk_length,
  output logic [$clog2(MAX_ENTRIES+1)-1:0] entry_count,
  output logic                             err_bad_length,
  output logic                             err_bad_reserved,
  output logic                             err_reserved_type,
  output logic                             err_truncated,
  output logic                             err_overflow,
  output logic [7:0]                       byte_sum,
  output logic [7:0]                       checksum,
  output logic                             busy,
  output logic                             finished
);

  localparam int PRE_W = (PRE_LEN < 1) ? 1 : $clog2(PRE_LEN + 1);

  // state
  logic              armed_q, fin_q, halt_q;
  logic [PRE_W-1:0]  pre_q;
  logic [15:0]       pos_q, len_q;
  logic [7:0]        typ_q;
  logic [OFFW-1:0]   offs_q, base_q;
  err_t              err_q;

  // effective state, as seen by the current byte (a start marker restarts)
  logic [PRE_W-1:0]  pre_e;
  logic [15:0]       pos_e, len_now;
  logic [OFFW-1:0]   offs_e;
  logic              halt_e;
  err_t              err_e, err_new;

  // named events
  logic take_w, restart_w, in_pre_w, parse_w, hdr_done_w, rsv_bad_w;
  logic len_ok_w, type_rsvd_w, hdr_bad_w, new_err_w, last_w, trunc_w;
  logic accept_w, rec_w, ovf_w, tbl_full_w;

  assign take_w    = in_valid && (in_start || armed_q);
  assign restart_w = take_w && in_start;

  assign pre_e  = restart_w ? '0 : pre_q;
  assign pos_e  = restart_w ? '0 : pos_q;
  assign offs_e = restart_w ? '0 : offs_q;
  assign halt_e = restart_w ? 1'b0 : halt_q;
  assign err_e  = restart_w ? '0 : err_q;

  assign in_pre_w   = (pre_e < PRE_W'(PRE_LEN));
  assign parse_w    = take_w && !in_pre_w && !halt_e;
  assign len_now    = (pos_e == 16'd3) ? {in_data, len_q[7:0]} : len_q;
  assign hdr_done_w = parse_w && (pos_e == 16'd3);
  assign rsv_bad_w  = parse_w && (pos_e == 16'd1) && (in_data != 8'd0);

  atv_hdr_rule u_rule (
    .typ       (typ_q),
    .len       (len_now),
    .len_ok    (len_ok_w),
    .type_rsvd (type_rsvd_w)
  );

  assign hdr_bad_w = hdr_done_w && (type_rsvd_w || !len_ok_w);
  assign new_err_w = rsv_bad_w || hdr_bad_w;
  assign last_w    = parse_w && (pos_e >= 16'(HDR_BYTES - 1)) && (pos_e == len_now - 16'd1);
  assign trunc_w   = take_w && in_end &&
                     (in_pre_w || (parse_w && !new_err_w && !last_w));
  assign accept_w  = hdr_done_w && !hdr_bad_w;
  assign rec_w     = accept_w && !tbl_full_w;
  assign ovf_w     = accept_w && tbl_full_w;

  always_comb begin
    err_new          = err_e;
    err_new.bad_len  = err_e.bad_len  | (hdr_bad_w && !type_rsvd_w);
    err_new.bad_rsv  = err_e.bad_rsv  | rsv_bad_w;
    err_new.rsv_type = err_e.rsv_type | (hdr_bad_w && type_rsvd_w);
    err_new.trunc    = err_e.trunc    | trunc_w;
    err_new.ovf      = err_e.ovf      | ovf_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      fin_q   <= 1'b0;
      halt_q  <= 1'b0;
      pre_q   <= '0;
      pos_q   <= '0;
      len_q   <= '0;
      typ_q   <= '0;
      offs_q  <= '0;
      base_q  <= '0;
      err_q   <= '0;
    end else if (take_w) begin
      armed_q <= !in_end;
      fin_q   <= in_end;
      pre_q   <= in_pre_w ? pre_e + 1'b1 : pre_e;
      halt_q  <= halt_e || new_err_w;
      err_q   <= err_new;
      pos_q   <= pos_e;
      offs_q  <= offs_e;
      if (parse_w) begin
        pos_q  <= last_w ? 16'd0 : pos_e + 16'd1;
        offs_q <= offs_e + 1'b1;
        if (pos_e == 16'd0) begin
          typ_q  <= in_data;
          base_q <= offs_e;
        end
        if (pos_e == 16'd2) len_q[7:0]  <= in_data;
        if (pos_e == 16'd3) len_q[15:8] <= in_data;
      end
    end
  end

  atv_entry_table #(.DEPTH(MAX_ENTRIES), .OFFW(OFFW)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (restart_w),
    .wr     (rec_w),
    .wr_off (base_q),
    .wr_len (len_now),
    .rd_idx (lk_idx),
    .rd_off (lk_offset),
    .rd_len (lk_length),
    .count  (entry_count),
    .full   (tbl_full_w)
  );

  atv_byte_sum u_sum (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (take_w),
    .clr  (restart_w),
    .data (in_data),
    .sum  (byte_sum)
  );

  assign checksum          = to_checksum(byte_sum);
  assign busy              = armed_q;
  assign finished          = fin_q;
  assign err_bad_length    = err_q.bad_len;
  assign err_bad_reserved  = err_q.bad_rsv;
  assign err_reserved_type = err_q.rsv_type;
  assign err_truncated     = err_q.trunc;
  assign err_overflow      = err_q.ovf;

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|err_q) && !restart_w) |=> ((err_q & $past(err_q)) == $past(err_q)));

  assert_halt_no_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !restart_w) |=> $stable(entry_count));

  assert_rsvd_type_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done_w && typ_q >= FIRST_RSVD_TYPE) |=> (err_reserved_type && !err_bad_length));

  assert_tiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_w && !in_end) |=> (pos_q == 16'd0 && offs_q == OFFW'($past(base_q) + $past(len_now))));

  assert_finish_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(finished && busy));

endmodule

// File: tb/sim_attr_table_validator.sv
module sim_attr_table_validator;

  localparam int PRE  = 4;
  localparam int MAXE = 8;
  localparam int IDXW = $clog2(MAXE);
  localparam int CNTW = $clog2(MAXE + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
  logic [7:0] in_data = '0;
  logic [IDXW-1:0] lk_idx = '0;
  logic [15:0] lk_offset, lk_length;
  logic [CNTW-1:0] entry_count;
  logic err_bad_length, err_bad_reserved, err_reserved_type, err_truncated, err_overflow;
  logic [7:0] byte_sum, checksum;
  logic busy, finished;

  always #4 clk = ~clk;

  attr_table_validator #(.PRE_LEN(PRE), .MAX_ENTRIES(MAXE), .OFFW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_start(in_start), .in_end(in_end), .lk_idx(lk_idx),
    .lk_offset(lk_offset), .lk_length(lk_length), .entry_count(entry_count),
    .err_bad_length(err_bad_length), .err_bad_reserved(err_bad_reserved),
    .err_reserved_type(err_reserved_type), .err_truncated(err_truncated),
    .err_overflow(err_overflow), .byte_sum(byte_sum), .checksum(checksum),
    .busy(busy), .finished(finished)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] sb [0:1023];
  int sn;
  bit e_bl, e_br, e_rt, e_tr, e_ov;
  int e_cnt;
  logic [7:0] e_sum;
  int e_off [0:MAXE-1];
  int e_len [0:MAXE-1];

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Allowed length table restated as a decision list.
  function automatic bit rule(int t, int l);
    if (t == 3) return l == 8;
    if (t == 2) return l == 20;
    if (t == 5) return (l >= 16) && ((l - 16) % 8 == 0);
    if (t == 0 || t == 1 || t == 4) return l == 24;
    return 0;
  endfunction

  function automatic int legal_len(int t);
    if (t == 2) return 20;
    if (t == 3) return 8;
    if (t == 5) return 16 + 8 * int'($urandom % 5);
    return 24;
  endfunction

  task automatic put(int b);
    sb[sn] = 8'(b);
    sn++;
  endtask

  task automatic begin_stream();
    sn = 0;
    for (int i = 0; i < PRE; i++) put(int'($urandom % 256));
  endtask

  task automatic add_struct(int t, int r, int l);
    put(t); put(r); put(l % 256); put(l / 256);
    for (int i = 4; i < l; i++) put(int'($urandom % 256));
  endtask

  task automatic model(int n);
    int idx, rem, t, l;
    e_bl = 0; e_br = 0; e_rt = 0; e_tr = 0; e_ov = 0; e_cnt = 0; e_sum = 0;
    for (int i = 0; i < MAXE; i++) begin e_off[i] = 0; e_len[i] = 0; end
    for (int i = 0; i < n; i++) e_sum = e_sum + sb[i];
    if (n <= PRE) begin e_tr = 1; return; end
    idx = PRE;
    forever begin
      rem = n - idx;
      if (rem == 0) break;
      if (rem >= 2 && sb[idx+1] != 0) begin e_br = 1; break; end
      if (rem < 4) begin e_tr = 1; break; end
      t = sb[idx];
      l = sb[idx+2] + 256 * sb[idx+3];
      if (t >= 6) begin e_rt = 1; break; end
      if (!rule(t, l)) begin e_bl = 1; break; end
      if (e_cnt < MAXE) begin
        e_off[e_cnt] = idx - PRE; e_len[e_cnt] = l; e_cnt++;
      end else e_ov = 1;
      if (rem < l) begin e_tr = 1; break; end
      idx += l;
    end
  endtask

  task automatic send(int n, bit with_start);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = sb[i];
      in_start = with_start && (i == 0);
      in_end = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
  endtask

  task automatic check_all(string tag);
    chk(tag, "bad_length", int'(err_bad_length), int'(e_bl));
    chk(tag, "bad_reserved", int'(err_bad_reserved), int'(e_br));
    chk(tag, "reserved_type", int'(err_reserved_type), int'(e_rt));
    chk(tag, "truncated", int'(err_truncated), int'(e_tr));
    chk(tag, "overflow R7", int'(err_overflow), int'(e_ov));
    chk(tag, "count R6", int'(entry_count), e_cnt);
    chk(tag, "sum R9", int'(byte_sum), int'(e_sum));
    chk(tag, "checksum R9", int'(8'(checksum + e_sum)), 0);
    chk(tag, "finished R11", int'(finished), 1);
    for (int i = 0; i < MAXE; i++) begin
      lk_idx = IDXW'(i);
      #1;
      chk(tag, "entry offset R10", int'(lk_offset), e_off[i]);
      chk(tag, "entry length R6", int'(lk_length), e_len[i]);
    end
  endtask

  task automatic run(string tag);
    send(sn, 1'b1);
    model(sn);
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seed, k, mode, bad, t, r, l;
    seed = int'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset count", int'(entry_count), 0);
    chk("R11", "reset flags", int'({err_bad_length, err_bad_reserved, err_reserved_type,
        err_truncated, err_overflow, finished, busy}), 0);
    chk("R11", "reset sum", int'(byte_sum), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 every fixed size accepted
    begin_stream();
    add_struct(2, 0, 20); add_struct(3, 0, 8); add_struct(0, 0, 24);
    add_struct(1, 0, 24); add_struct(4, 0, 24);
    run("R2");
    // R2 wrong fixed size
    begin_stream(); add_struct(3, 0, 8); add_struct(0, 0, 20); add_struct(3, 0, 8);
    run("R2");
    // R3 record-list type boundaries
    begin_stream(); add_struct(5, 0, 16); add_struct(5, 0, 24); run("R3");
    begin_stream(); add_struct(5, 0, 20); run("R3");
    begin_stream(); add_struct(5, 0, 8); run("R3");
    // R1 zero length and nonzero reserved byte
    begin_stream(); add_struct(3, 0, 0); run("R1");
    begin_stream(); add_struct(3, 0, 8); add_struct(3, 5, 8); add_struct(3, 0, 8); run("R1");
    // R4 reserved type
    begin_stream(); add_struct(7, 0, 8); run("R4");
    begin_stream(); add_struct(6, 0, 24); run("R4");
    // R7 overflow
    begin_stream();
    for (int i = 0; i < MAXE + 2; i++) add_struct(3, 0, 8);
    run("R7");
    // R10 end inside preamble and exactly at its last byte
    sn = 0; put(1); put(2); put(3); run("R10");
    begin_stream(); run("R10");
    // R5 truncation: last byte missing, end inside a header
    begin_stream(); add_struct(2, 0, 20); add_struct(3, 0, 8); sn--; run("R5");
    begin_stream(); add_struct(3, 0, 8); put(3); put(0); run("R5");
    // R8 restart clears errors
    begin_stream(); add_struct(9, 0, 8); run("R8");
    begin_stream(); add_struct(3, 0, 8); run("R8");
    // R11 bytes after end without a start are ignored
    sb[0] = 8'h55; sb[1] = 8'h03; sb[2] = 8'h00;
    send(3, 1'b0);
    chk("R11", "ignored count", int'(entry_count), e_cnt);
    chk("R11", "ignored sum", int'(byte_sum), int'(e_sum));
    chk("R11", "ignored flags", int'(err_bad_reserved | err_truncated), 0);

    // constrained random streams with one optional injected fault
    for (int s = 0; s < 60; s++) begin
      begin_stream();
      k = 1 + int'($urandom % 10);
      mode = int'($urandom % 5);
      bad = int'($urandom % k);
      for (int j = 0; j < k; j++) begin
        t = int'($urandom % 6); r = 0; l = legal_len(t);
        if (j == bad && mode == 1) r = 1 + int'($urandom % 255);
        if (j == bad && mode == 2) l = l + 4;
        if (j == bad && mode == 3) t = 6 + int'($urandom % 250);
        add_struct(t, r, l);
      end
      if (mode == 4) sn = sn - (1 + int'($urandom % 3));
      run("R5");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule